// File: doc/BRIEF.md
# Accelerometer Self-Test Sequencer

This block runs one timed self-test on a stream of signed ADC samples. A start pulse launches a sequence that is counted in accepted samples: a settling gap, a baseline average, a period with the test stimulus enabled (a settling gap, then an average of the deflected output), a settling gap after the stimulus is removed, a second baseline average, and a hold period. The sequence always spans a fixed number of sample periods. The three averages are then compared with programmable limits.

The result appears on a done flag, a pass flag and a two-bit error code. A clean result can be re-run with another start pulse. A failure latches its code until reset, and the block then refuses further runs. Samples only count in cycles where the valid strobe is high, so the sequence length does not depend on the sample rate.

Top module: `st_selftest_seq`

## Requirements
- R1: After reset, `stim_on`, `run_done` and `run_pass` are 0 and `fault_code` is 2'b00.
- R2: A `start` pulse is accepted only when no run is active, `fault_code` is 00 and the block is idle or finished. Samples with `smp_vld` low are not counted. A `start` during a run has no effect on its timing or result.
- R3: The accepted samples are counted from 0 to 1727. Numbers 0–31 are skipped. Numbers 32–95 form the first baseline average. `stim_on` is high while samples 96–191 are presented: 96–127 are skipped and 128–191 form the stimulus average. Numbers 192–223 are skipped, 224–287 form the second baseline average and 288–1727 are held. `run_done` rises on the second clock edge after sample 1727 is accepted.
- R4: Each average is the sum of its 64 samples shifted right arithmetically by 6, which is the floor of the mean, so a mean of −0.5 gives −1.
- R5: Offset check: the first baseline average must lie within [`off_lo`, `off_hi`], bounds included. A failure gives code 2'b01.
- R6: Deflection check: the stimulus average minus the first baseline average must lie within [`dfl_lo`, `dfl_hi`], bounds included. A failure gives code 2'b10.
- R7: Return-to-zero check: the absolute difference between the two baseline averages must be below 4. A failure gives code 2'b11.
- R8: When several checks fail, the reported code follows the priority offset, then deflection, then return-to-zero.
- R9: A run with no failure gives `run_pass`=1 and `fault_code`=00. `run_done` stays high until the next accepted `start`, which clears `run_done` and `run_pass` one edge later.
- R10: A nonzero `fault_code` holds until reset. In that state `run_done` stays 1, `run_pass` stays 0, `stim_on` stays 0 and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a self-test run |
| smp_vld | input | 1 | Sample strobe |
| smp | input | SW (10) | Signed ADC sample |
| off_lo | input | SW (10) | Signed minimum of the first baseline average |
| off_hi | input | SW (10) | Signed maximum of the first baseline average |
| dfl_lo | input | SW+1 (11) | Signed minimum deflection |
| dfl_hi | input | SW+1 (11) | Signed maximum deflection |
| stim_on | output | 1 | Test stimulus enable |
| run_done | output | 1 | Run finished |
| run_pass | output | 1 | Finished run passed every check |
| fault_code | output | 2 | Latched error code: 00 none, 01 offset, 10 deflection, 11 return-to-zero |

## Verification
The embedded assertions check these properties on every cycle:
- the phase counter stays inside the length of its phase;
- every run spans exactly 1728 strobed samples;
- the stimulus is off whenever a result is shown;
- a latched fault holds its code and keeps `run_done` high;
- pass never appears alongside a fault.

The bench scenarios cover what the assertions cannot reach:
- the exact sample numbers at which the stimulus turns on and off;
- the floor behaviour of the averages on negative half-LSB means;
- the inclusive limit boundaries;
- the priority between failing checks;
- rejection of `start` while a run is active or after a fault.

// File: rtl/st_pkg.sv
package st_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_SET0, PH_AVGZ1, PH_SETON, PH_AVGON,
    PH_SETOFF, PH_AVGZ2, PH_HOLD, PH_EVAL, PH_DONE
  } st_phase_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00, FLT_OFFSET = 2'b01, FLT_DEFL = 2'b10, FLT_RTZ = 2'b11
  } st_fault_e;
endpackage

// File: rtl/st_phase_ctrl.sv
module st_phase_ctrl
  import st_pkg::*;
#(
  parameter int SETTLE_LEN = 32,
  parameter int AVG_LEN    = 64,
  parameter int TOTAL_LEN  = 1728
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_go,
  input  logic      smp_vld,
  output st_phase_e phase,
  output logic      take,
  output logic      first_smp,
  output logic      last_smp,
  output logic      eval_now
);
  localparam int HOLD_LEN = TOTAL_LEN - 3 * SETTLE_LEN - 3 * AVG_LEN;
  localparam int CW       = $clog2(TOTAL_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          counting;

  function automatic logic [CW-1:0] phase_len(st_phase_e p);
    case (p)
      PH_SET0, PH_SETON, PH_SETOFF: phase_len = CW'(SETTLE_LEN);
      PH_AVGZ1, PH_AVGON, PH_AVGZ2: phase_len = CW'(AVG_LEN);
      PH_HOLD:                      phase_len = CW'(HOLD_LEN);
      default:                      phase_len = CW'(1);
    endcase
  endfunction

  function automatic st_phase_e phase_after(st_phase_e p);
    case (p)
      PH_SET0:   phase_after = PH_AVGZ1;
      PH_AVGZ1:  phase_after = PH_SETON;
      PH_SETON:  phase_after = PH_AVGON;
      PH_AVGON:  phase_after = PH_SETOFF;
      PH_SETOFF: phase_after = PH_AVGZ2;
      PH_AVGZ2:  phase_after = PH_HOLD;
      PH_HOLD:   phase_after = PH_EVAL;
      default:   phase_after = PH_DONE;
    endcase
  endfunction

  assign counting  = (phase == PH_SET0) || (phase == PH_AVGZ1) || (phase == PH_SETON) ||
                     (phase == PH_AVGON) || (phase == PH_SETOFF) || (phase == PH_AVGZ2) ||
                     (phase == PH_HOLD);
  assign take      = smp_vld && counting;
  assign first_smp = take && (cnt_q == '0);
  assign last_smp  = take && (cnt_q == phase_len(phase) - CW'(1));
  assign eval_now  = (phase == PH_EVAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else if (start_go) begin
      phase <= PH_SET0;
      cnt_q <= '0;
    end else if (eval_now) begin
      phase <= PH_DONE;
    end else if (take) begin
      if (last_smp) begin
        phase <= phase_after(phase);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R3: the sample index never leaves the window of its phase
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (cnt_q < phase_len(phase)));
endmodule

// File: rtl/st_accum.sv
module st_accum #(
  parameter int SW       = 10,
  parameter int LOG2_AVG = 6,
  parameter int NSLOT    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 add,
  input  logic                 first_smp,
  input  logic                 last_smp,
  input  logic [1:0]           slot,
  input  logic signed [SW-1:0] smp,
  output logic signed [SW-1:0] avg [NSLOT]
);
  localparam int AW = SW + LOG2_AVG;

  logic signed [AW-1:0] acc_q, acc_nx, mean_full;

  // floor of the mean: arithmetic shift of the running sum
  function automatic logic signed [SW-1:0] floor_mean(logic signed [AW-1:0] s);
    logic signed [AW-1:0] sh;
    sh = s >>> LOG2_AVG;
    return sh[SW-1:0];
  endfunction

  assign acc_nx    = (first_smp ? AW'(0) : acc_q) + {{LOG2_AVG{smp[SW-1]}}, smp};
  assign mean_full = acc_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (add) acc_q <= acc_nx;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   avg[g] <= '0;
      else if (add && last_smp && (slot == 2'(g))) avg[g] <= floor_mean(mean_full);
    end
  end

  // R4: an averaging sample always addresses an existing result slot
  assert_slot_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    add |-> (int'(slot) < NSLOT));
endmodule

// File: rtl/st_judge.sv
module st_judge
  import st_pkg::*;
#(
  parameter int SW      = 10,
  parameter int RTZ_LIM = 4
) (
  input  logic signed [SW-1:0] zero_a,
  input  logic signed [SW-1:0] stim_avg,
  input  logic signed [SW-1:0] zero_b,
  input  logic signed [SW-1:0] off_lo,
  input  logic signed [SW-1:0] off_hi,
  input  logic signed [SW:0]   dfl_lo,
  input  logic signed [SW:0]   dfl_hi,
  output st_fault_e            verdict
);
  logic signed [SW:0] defl, drift;

  function automatic logic signed [SW:0] widen_sub(logic signed [SW-1:0] a, logic signed [SW-1:0] b);
    return {a[SW-1], a} - {b[SW-1], b};
  endfunction

  function automatic logic in_window(logic signed [SW:0] v, logic signed [SW:0] lo, logic signed [SW:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic small_drift(logic signed [SW:0] d);
    return (d < (SW+1)'(RTZ_LIM)) && (d > -(SW+1)'(RTZ_LIM));
  endfunction

  assign defl  = widen_sub(stim_avg, zero_a);
  assign drift = widen_sub(zero_a, zero_b);

  always_comb begin
    if (!in_window({zero_a[SW-1], zero_a}, {off_lo[SW-1], off_lo}, {off_hi[SW-1], off_hi}))
      verdict = FLT_OFFSET;
    else if (!in_window(defl, dfl_lo, dfl_hi))
      verdict = FLT_DEFL;
    else if (!small_drift(drift))
      verdict = FLT_RTZ;
    else
      verdict = FLT_NONE;
  end
endmodule

// File: rtl/st_selftest_seq.sv
module st_selftest_seq
  import st_pkg::*;
#(
  parameter int SW         = 10,
  parameter int LOG2_AVG   = 6,
  parameter int SETTLE_LEN = 32,
  parameter int TOTAL_LEN  = 1728,
  parameter int RTZ_LIM    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] smp,
  input  logic signed [SW-1:0] off_lo,
  input  logic signed [SW-1:0] off_hi,
  input  logic signed [SW:0]   dfl_lo,
  input  logic signed [SW:0]   dfl_hi,
  output logic                 stim_on,
  output logic                 run_done,
  output logic                 run_pass,
  output logic [1:0]           fault_code
);
  localparam int AVG_LEN = 1 << LOG2_AVG;
  localparam int RCW     = $clog2(TOTAL_LEN + 2);

  st_phase_e          phase;
  logic               take, first_smp, last_smp, eval_now;
  logic               start_go, avg_add;
  logic [1:0]         slot;
  logic signed [SW-1:0] avg [3];
  st_fault_e          verdict;

  assign start_go = start && (fault_code == 2'b00) && ((phase == PH_IDLE) || (phase == PH_DONE));
  assign avg_add  = take && ((phase == PH_AVGZ1) || (phase == PH_AVGON) || (phase == PH_AVGZ2));
  assign slot     = (phase == PH_AVGON) ? 2'd1 : (phase == PH_AVGZ2) ? 2'd2 : 2'd0;
  assign stim_on  = (phase == PH_SETON) || (phase == PH_AVGON);

  st_phase_ctrl #(.SETTLE_LEN(SETTLE_LEN), .AVG_LEN(AVG_LEN), .TOTAL_LEN(TOTAL_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .smp_vld(smp_vld), .phase(phase),
    .take(take), .first_smp(first_smp), .last_smp(last_smp), .eval_now(eval_now)
  );

  st_accum #(.SW(SW), .LOG2_AVG(LOG2_AVG), .NSLOT(3)) u_accum (
    .clk(clk), .rst_n(rst_n), .add(avg_add), .first_smp(first_smp), .last_smp(last_smp),
    .slot(slot), .smp(smp), .avg(avg)
  );

  st_judge #(.SW(SW), .RTZ_LIM(RTZ_LIM)) u_judge (
    .zero_a(avg[0]), .stim_avg(avg[1]), .zero_b(avg[2]), .off_lo(off_lo), .off_hi(off_hi),
    .dfl_lo(dfl_lo), .dfl_hi(dfl_hi), .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_done   <= 1'b0;
      run_pass   <= 1'b0;
      fault_code <= 2'b00;
    end else if (start_go) begin
      run_done <= 1'b0;
      run_pass <= 1'b0;
    end else if (eval_now) begin
      run_done   <= 1'b1;
      run_pass   <= (verdict == FLT_NONE);
      fault_code <= verdict;
    end
  end

  // run-length checker: strobes from acceptance to evaluation
  logic           chk_run;
  logic [RCW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_run <= 1'b0;
      chk_cnt <= '0;
    end else if (start_go) begin
      chk_run <= 1'b1;
      chk_cnt <= '0;
    end else if (eval_now) begin
      chk_run <= 1'b0;
    end else if (chk_run && smp_vld) begin
      chk_cnt <= chk_cnt + RCW'(1);
    end
  end

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_done) |-> (chk_cnt == RCW'(TOTAL_LEN)));
  assert_stim_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> !stim_on);
  assert_pass_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_pass |-> (run_done && (fault_code == 2'b00)));
  assert_fault_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 2'b00) |=> ((fault_code == $past(fault_code)) && run_done));
endmodule

// File: tb/st_selftest_seq_bench.sv
`timescale 1ns/100ps
module st_selftest_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [9:0]  smp = '0;
  logic signed [9:0]  off_lo = -10'sd20, off_hi = 10'sd20;
  logic signed [10:0] dfl_lo = 11'sd50, dfl_hi = 11'sd200;
  logic stim_on, run_done, run_pass;
  logic [1:0] fault_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct { int code; int pass; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  st_selftest_seq u_st_selftest_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld), .smp(smp),
    .off_lo(off_lo), .off_hi(off_hi), .dfl_lo(dfl_lo), .dfl_hi(dfl_hi),
    .stim_on(stim_on), .run_done(run_done), .run_pass(run_pass), .fault_code(fault_code)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // floor of s/64 without shifts
  function automatic int floor64(int s);
    if (s >= 0) return s / 64;
    return -((-s + 63) / 64);
  endfunction

  function automatic int wval(int base, bit alt, int i);
    return alt ? base + (i % 2) : base;
  endfunction

  // monitor: pops the scoreboard when a result appears
  bit done_seen = 0;
  always @(negedge clk) begin
    if (!rst_n) done_seen = 0;
    else begin
      if (run_done && !done_seen) begin
        if (exp_q.size() == 0) check("R9", "unexpected result", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R5-R8 code", "fault_code", int'(fault_code), e.code);
          check("R9", "run_pass", int'(run_pass), e.pass);
        end
      end
      done_seen = run_done;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; smp_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_seq(int z1v, bit z1a, int onv, bit ona, int z2v, bit z2a, bit gap, bit mid_start);
    int s1 = 0, s2 = 0, s3 = 0;
    int a1, a2, a3, d, code;
    exp_t e;
    for (int i = 0; i < 64; i++) begin
      s1 += wval(z1v, z1a, i); s2 += wval(onv, ona, i); s3 += wval(z2v, z2a, i);
    end
    a1 = floor64(s1); a2 = floor64(s2); a3 = floor64(s3);
    d = a2 - a1;
    if (a1 < int'(off_lo) || a1 > int'(off_hi)) code = 1;
    else if (d < int'(dfl_lo) || d > int'(dfl_hi)) code = 2;
    else if (a1 - a3 >= 4 || a3 - a1 >= 4) code = 3;
    else code = 0;
    e.code = code; e.pass = (code == 0);
    exp_q.push_back(e);

    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "run_done cleared on start", int'(run_done), 0);
    for (int idx = 0; idx < 1728; idx++) begin
      int v;
      if (mid_start && idx == 500) begin
        start = 1'b1; smp_vld = 1'b0;
        @(negedge clk);
        start = 1'b0;
      end
      if (gap) begin
        smp_vld = 1'b0; smp = 10'sd511;
        @(negedge clk);
      end
      if (idx >= 32 && idx < 96)        v = wval(z1v, z1a, idx - 32);
      else if (idx >= 128 && idx < 192) v = wval(onv, ona, idx - 128);
      else if (idx >= 224 && idx < 288) v = wval(z2v, z2a, idx - 224);
      else if ((idx / 32) % 2 == 0)     v = 300;
      else                              v = -300;
      smp_vld = 1'b1; smp = 10'(v);
      if (idx == 95 || idx == 96 || idx == 191 || idx == 192 || idx == 0 || idx == 1727)
        check("R3", $sformatf("stim_on at sample %0d", idx), int'(stim_on), (idx >= 96 && idx <= 191) ? 1 : 0);
      @(negedge clk);
    end
    smp_vld = 1'b0;
    check("R3", "run_done one edge after last sample", int'(run_done), 0);
    @(negedge clk);
    check("R3", "run_done two edges after last sample", int'(run_done), 1);
    @(negedge clk);
    check("R9", "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "stim_on", int'(stim_on), 0);
    check("R1", "run_done", int'(run_done), 0);
    check("R1", "run_pass", int'(run_pass), 0);
    check("R1", "fault_code", int'(fault_code), 0);
    rst_n = 1'b1;

    // R2 R4: passing run with strobe gaps and a stray start mid-run
    run_seq(3, 1, 103, 1, 4, 1, 1, 1);
    repeat (5) @(negedge clk);
    check("R9", "run_done held", int'(run_done), 1);
    check("R9", "run_pass held", int'(run_pass), 1);

    // R5 R6 R7 inclusive boundaries: offset 20, deflection 200, drift 3
    run_seq(20, 0, 220, 0, 17, 0, 0, 0);

    // R5 R8: offset and deflection both fail -> offset code
    run_seq(21, 0, 21, 0, 21, 0, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    smp_vld = 1'b1;
    repeat (10) @(negedge clk);
    smp_vld = 1'b0;
    check("R10", "start ignored: run_done", int'(run_done), 1);
    check("R10", "start ignored: stim_on", int'(stim_on), 0);
    check("R10", "start ignored: fault_code", int'(fault_code), 1);
    check("R10", "start ignored: run_pass", int'(run_pass), 0);

    // R6 R8: deflection 49 and drift 10 -> deflection code
    do_reset();
    check("R1", "fault cleared by reset", int'(fault_code), 0);
    run_seq(0, 0, 49, 0, 10, 0, 0, 0);

    // R7: drift exactly 4 fails
    do_reset();
    run_seq(0, 0, 100, 0, -4, 0, 0, 0);

    // R4: floor averaging, window [0,0]
    do_reset();
    off_lo = 10'sd0; off_hi = 10'sd0;
    run_seq(0, 1, 100, 1, -1, 1, 0, 0);
    do_reset();
    run_seq(-1, 1, 100, 0, 0, 0, 0, 0);

    finished = 1;
    report();
    $finish;
  end
endmodule